// File: doc/BRIEF.md
# SIMD Vector Lane Compare Unit

This unit compares two 128-bit SIMD operand vectors lane by lane and returns a 128-bit mask. In that mask every bit of a lane is set when the lane's test holds and clear when it does not. The lane width can be 8, 16 or 32 bits for integer data, and the integers can be signed or unsigned. A single-precision floating-point mode always uses four 32-bit lanes. The tests are greater-than, greater-or-equal and equal. Each test is applied as the first operand against the second (n against m).

The caller presents a 32-bit instruction word, an opcode-group bit and the two operands, qualified by a valid strobe. A control block decodes the instruction fields into a small set of strobes. A datapath block evaluates every lane width in parallel and registers the selected mask. Result, valid and undefined-encoding flag all appear one clock after the request. An encoding that names none of the supported compares, including an integer compare with size code 3, is reported as undefined and gives an all-zero mask.

Top module: `vec_lane_cmp`

## Requirements
- R1: Size code instr[21:20] selects integer lane width: 0 gives sixteen 8-bit lanes, 1 gives eight 16-bit lanes, 2 gives four 32-bit lanes. Lane k occupies bits [k*W+W-1 : k*W].
- R2: Each result lane is all ones when its test holds and all zeros otherwise.
- R3: With group bit 0 and instr[11:8]=3, lanes are compared as two's-complement signed values. instr[4]=1 selects n>=m and instr[4]=0 selects n>m.
- R4: With group bit 1 and instr[11:8]=3, lanes are compared as unsigned magnitudes. instr[4] selects GE (1) or GT (0) as in R3.
- R5: With group bit 1, instr[11:8]=8 and instr[4]=1, integer lanes of the R1 width are tested for n==m.
- R6: With group bit 1, instr[11:8]=0xE, instr[4]=0 and instr[20]=0, four 32-bit single-precision lanes are compared. instr[21]=0 selects GE and instr[21]=1 selects GT.
- R7: With group bit 0, instr[21:20]=0, instr[11:8]=0xE and instr[4]=0, four single-precision lanes are tested for n==m.
- R8: In float lanes, a NaN in either operand (exponent all ones, fraction nonzero) makes EQ, GE and GT false. +0 and -0 compare equal. Infinities order beyond all finite values.
- R9: An integer compare with size code 3, or any encoding not listed in R3 to R7, raises the undefined flag and returns an all-zero mask.
- R10: Result, valid and undefined flag appear one clock after an accepted request. No valid output follows a cycle without a request, and synchronous reset clears the valid output.
- R11: For any operands without NaN, the GT result for (n, m) is the bitwise complement of the GE result for (m, n).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Request strobe |
| inInstr | input | 32 | Instruction word carrying the compare fields |
| inUGroup | input | 1 | Opcode group bit (unsigned / float-ordered group when 1) |
| opN | input | 128 | First operand vector |
| opM | input | 128 | Second operand vector |
| outValid | output | 1 | Result valid, one cycle after request |
| outUndef | output | 1 | Undefined encoding flag for the returned result |
| outMask | output | 128 | Per-lane compare mask |

## Verification
Every result of this unit, including the mask, the valid and the undefined flag, is due exactly one clock edge after the request is driven. No request is held or merged. The bench drives each request just after a falling edge and keeps the expected mask and flag from its own behavioural model in a one-entry pending slot. At the next falling edge it compares the outputs with that slot, before it drives the following request, so every comparison falls after the single register stage. The R11 swap pairs are sent back to back, and each second result is compared against the complement of the first.

// File: rtl/vcmp_pkg.sv
package vcmp_pkg;
  typedef enum logic [1:0] {CMP_EQ = 2'd0, CMP_GE = 2'd1, CMP_GT = 2'd2} cmpKind_e;
  typedef enum logic [1:0] {FMT_SINT = 2'd0, FMT_UINT = 2'd1, FMT_FP = 2'd2} cmpFmt_e;

  typedef struct packed {
    logic     load;
    logic     undef;
    cmpFmt_e  fmt;
    cmpKind_e kind;
    logic [1:0] laneSize;
  } cmpStrobe_t;

  localparam logic [3:0] FLD_INT_ORD = 4'h3;
  localparam logic [3:0] FLD_INT_EQ  = 4'h8;
  localparam logic [3:0] FLD_FP      = 4'hE;
endpackage

// File: rtl/vcmp_ctrl.sv
module vcmp_ctrl
  import vcmp_pkg::*;
#(
  parameter int INSTR_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [INSTR_W-1:0] inInstr,
  input  logic               inUGroup,
  output cmpStrobe_t         strobe,
  output logic               outValid,
  output logic               outUndef
);
  logic [3:0] fieldOp;
  logic [1:0] fieldSize;
  logic       bit4;
  logic       bit20;
  logic       bit21;
  logic       isIntOrd;
  logic       isIntEq;
  logic       isFpOrd;
  logic       isFpEq;

  assign fieldOp   = inInstr[11:8];
  assign fieldSize = inInstr[21:20];
  assign bit4      = inInstr[4];
  assign bit20     = inInstr[20];
  assign bit21     = inInstr[21];

  assign isIntOrd = (fieldOp == FLD_INT_ORD);
  assign isIntEq  = inUGroup && (fieldOp == FLD_INT_EQ) && bit4;
  assign isFpOrd  = inUGroup && (fieldOp == FLD_FP) && !bit4 && !bit20;
  assign isFpEq   = !inUGroup && (fieldSize == 2'd0) && (fieldOp == FLD_FP) && !bit4;

  always_comb begin
    strobe.load     = inValid;
    strobe.undef    = 1'b1;
    strobe.fmt      = FMT_UINT;
    strobe.kind     = CMP_EQ;
    strobe.laneSize = fieldSize;
    if (isIntOrd) begin
      strobe.fmt   = inUGroup ? FMT_UINT : FMT_SINT;
      strobe.kind  = bit4 ? CMP_GE : CMP_GT;
      strobe.undef = (fieldSize == 2'd3);
    end else if (isIntEq) begin
      strobe.fmt   = FMT_UINT;
      strobe.kind  = CMP_EQ;
      strobe.undef = (fieldSize == 2'd3);
    end else if (isFpOrd) begin
      strobe.fmt      = FMT_FP;
      strobe.kind     = bit21 ? CMP_GT : CMP_GE;
      strobe.laneSize = 2'd2;
      strobe.undef    = 1'b0;
    end else if (isFpEq) begin
      strobe.fmt      = FMT_FP;
      strobe.kind     = CMP_EQ;
      strobe.laneSize = 2'd2;
      strobe.undef    = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outUndef <= 1'b0;
    end else begin
      outValid <= inValid;
      if (inValid) outUndef <= strobe.undef;
    end
  end
endmodule

// File: rtl/vcmp_datapath.sv
module vcmp_datapath
  import vcmp_pkg::*;
#(
  parameter int VEC_W   = 128,
  parameter int FP_W    = 32,
  parameter int N_SIZES = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  cmpStrobe_t       strobe,
  input  logic [VEC_W-1:0] opN,
  input  logic [VEC_W-1:0] opM,
  output logic [VEC_W-1:0] outMask
);
  localparam int FP_LANES = VEC_W / FP_W;
  localparam int EXP_MSB  = FP_W - 2;
  localparam int FRAC_W   = 23;

  logic [N_SIZES-1:0][VEC_W-1:0] intMask;
  logic [VEC_W-1:0]              fpMask;
  logic [VEC_W-1:0]              nextMask;
  logic                          signExt;

  assign signExt = (strobe.fmt == FMT_SINT);

  function automatic logic pickHit(input cmpKind_e k, input logic gt, input logic eq);
    case (k)
      CMP_EQ:  pickHit = eq;
      CMP_GE:  pickHit = gt | eq;
      CMP_GT:  pickHit = gt;
      default: pickHit = 1'b0;
    endcase
  endfunction

  // integer lanes, one generated bank per lane width
  for (genvar g = 0; g < N_SIZES; g++) begin : gSize
    localparam int LW = 8 << g;
    localparam int NL = VEC_W / LW;
    logic [VEC_W-1:0] bankMask;
    for (genvar l = 0; l < NL; l++) begin : gLane
      logic signed [LW:0] laneA;
      logic signed [LW:0] laneB;
      logic               laneHit;
      always_comb begin
        laneA   = {signExt & opN[l*LW+LW-1], opN[l*LW +: LW]};
        laneB   = {signExt & opM[l*LW+LW-1], opM[l*LW +: LW]};
        laneHit = pickHit(strobe.kind, laneA > laneB, laneA == laneB);
      end
      assign bankMask[l*LW +: LW] = {LW{laneHit}};
    end
    assign intMask[g] = bankMask;
  end

  // single-precision lanes, ordered on the raw bit pattern
  for (genvar f = 0; f < FP_LANES; f++) begin : gFp
    logic [FP_W-1:0] a;
    logic [FP_W-1:0] b;
    logic nanA, nanB, anyNan, bothZero, magGt, magLt, fpGt, fpEq, fpHit;
    always_comb begin
      a        = opN[f*FP_W +: FP_W];
      b        = opM[f*FP_W +: FP_W];
      nanA     = (&a[EXP_MSB -: 8]) && (|a[FRAC_W-1:0]);
      nanB     = (&b[EXP_MSB -: 8]) && (|b[FRAC_W-1:0]);
      anyNan   = nanA | nanB;
      bothZero = (a[FP_W-2:0] == '0) && (b[FP_W-2:0] == '0);
      magGt    = a[FP_W-2:0] > b[FP_W-2:0];
      magLt    = a[FP_W-2:0] < b[FP_W-2:0];
      fpEq     = !anyNan && ((a == b) || bothZero);
      if (anyNan || bothZero)           fpGt = 1'b0;
      else if (a[FP_W-1] != b[FP_W-1])  fpGt = !a[FP_W-1];
      else if (a[FP_W-1])               fpGt = magLt;
      else                              fpGt = magGt;
      fpHit = pickHit(strobe.kind, fpGt, fpEq);
    end
    assign fpMask[f*FP_W +: FP_W] = {FP_W{fpHit}};
  end

  always_comb begin
    nextMask = '0;
    if (!strobe.undef) begin
      if (strobe.fmt == FMT_FP) begin
        nextMask = fpMask;
      end else begin
        for (int s = 0; s < N_SIZES; s++)
          if (strobe.laneSize == s[1:0]) nextMask = intMask[s];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) outMask <= '0;
    else if (strobe.load) outMask <= nextMask;
  end
endmodule

// File: rtl/vec_lane_cmp.sv
module vec_lane_cmp
  import vcmp_pkg::*;
#(
  parameter int VEC_W   = 128,
  parameter int INSTR_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [INSTR_W-1:0] inInstr,
  input  logic               inUGroup,
  input  logic [VEC_W-1:0]   opN,
  input  logic [VEC_W-1:0]   opM,
  output logic               outValid,
  output logic               outUndef,
  output logic [VEC_W-1:0]   outMask
);
  cmpStrobe_t strobe;

  vcmp_ctrl #(.INSTR_W(INSTR_W)) u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inInstr(inInstr),
    .inUGroup(inUGroup), .strobe(strobe), .outValid(outValid),
    .outUndef(outUndef)
  );

  vcmp_datapath #(.VEC_W(VEC_W)) u_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .opN(opN), .opM(opM),
    .outMask(outMask)
  );
endmodule

// File: rtl/vcmp_chk.sv
module vcmp_chk #(
  parameter int VEC_W   = 128,
  parameter int INSTR_W = 32
) (
  input logic               clk,
  input logic               rst,
  input logic               inValid,
  input logic [INSTR_W-1:0] inInstr,
  input logic               inUGroup,
  input logic               outValid,
  input logic               outUndef,
  input logic [VEC_W-1:0]   outMask
);
  function automatic logic bytesUniform(input logic [VEC_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < VEC_W/8; i++)
      if (v[i*8 +: 8] != 8'h00 && v[i*8 +: 8] != 8'hFF) ok = 1'b0;
    return ok;
  endfunction

  function automatic logic wordsUniform(input logic [VEC_W-1:0] v);
    logic ok;
    ok = 1'b1;
    for (int i = 0; i < VEC_W/32; i++)
      if (v[i*32 +: 32] != 32'h0 && v[i*32 +: 32] != 32'hFFFF_FFFF) ok = 1'b0;
    return ok;
  endfunction

  // R10
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  // R10
  valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);
  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> !outValid);
  // R9
  size3_undef_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && inInstr[11:8] == 4'h3 && inInstr[21:20] == 2'b11) |=> (outUndef && outMask == '0));
  // R9
  undef_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && outUndef) |-> (outMask == '0));
  // R2
  lane_uniform_chk: assert property (@(posedge clk) disable iff (rst)
    outValid |-> bytesUniform(outMask));
  // R6
  fp_word_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && inUGroup && inInstr[11:8] == 4'hE && !inInstr[4] && !inInstr[20])
      |=> (!outUndef && wordsUniform(outMask)));
endmodule

bind vec_lane_cmp vcmp_chk #(.VEC_W(VEC_W), .INSTR_W(INSTR_W)) u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inInstr(inInstr),
  .inUGroup(inUGroup), .outValid(outValid), .outUndef(outUndef),
  .outMask(outMask)
);

// File: tb/tb_vec_lane_cmp.sv
module tb_vec_lane_cmp;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [31:0]  inInstr = '0;
  logic         inUGroup = 1'b0;
  logic [127:0] opN = '0;
  logic [127:0] opM = '0;
  logic         outValid;
  logic         outUndef;
  logic [127:0] outMask;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  bit           havePend = 0;
  logic [127:0] pendMask;
  logic         pendUndef;
  int           pendReq;
  bit           pendSwap;
  logic [127:0] lastMask = '0;

  always #4 clk = ~clk;

  vec_lane_cmp dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inInstr(inInstr),
    .inUGroup(inUGroup), .opN(opN), .opM(opM), .outValid(outValid),
    .outUndef(outUndef), .outMask(outMask)
  );

  function automatic real toReal(input logic [31:0] x);
    int  e;
    real v;
    e = int'(x[30:23]);
    if (e == 255) v = 1.0e300;
    else if (e == 0) v = real'(x[22:0]) * (2.0 ** (-149));
    else v = (1.0 + real'(x[22:0]) / 8388608.0) * (2.0 ** (e - 127));
    return x[31] ? -v : v;
  endfunction

  // kind: 0 equal, 1 greater-or-equal, 2 greater
  function automatic bit fpRef(input logic [31:0] a, input logic [31:0] b, input int kind);
    bit  nan;
    real ra, rb;
    nan = (a[30:23] == 8'hFF && a[22:0] != 0) || (b[30:23] == 8'hFF && b[22:0] != 0);
    if (nan) return 0;
    ra = toReal(a);
    rb = toReal(b);
    if (kind == 0) return ra == rb;
    if (kind == 1) return ra >= rb;
    return ra > rb;
  endfunction

  task automatic refModel(input logic [31:0] ins, input logic u, input logic [127:0] n,
                          input logic [127:0] m, output logic [127:0] mk, output logic ud);
    int  kind, sz, lw;
    bit  fp, sg, hit;
    longint a, b;
    mk = '0; ud = 0; kind = -1; fp = 0; sg = 0;
    sz = int'(ins[21:20]);
    if (ins[11:8] == 4'd3) begin kind = ins[4] ? 1 : 2; sg = !u; end
    else if (u && ins[11:8] == 4'd8 && ins[4]) kind = 0;
    else if (u && ins[11:8] == 4'hE && !ins[4] && !ins[20]) begin fp = 1; kind = ins[21] ? 2 : 1; end
    else if (!u && ins[21:20] == 0 && ins[11:8] == 4'hE && !ins[4]) begin fp = 1; kind = 0; end
    if (kind < 0 || (!fp && sz == 3)) begin ud = 1; return; end
    if (fp) begin
      for (int i = 0; i < 4; i++) begin
        hit = fpRef(n[i*32 +: 32], m[i*32 +: 32], kind);
        for (int k = 0; k < 32; k++) mk[i*32+k] = hit;
      end
    end else begin
      lw = 8 << sz;
      for (int i = 0; i < 128/lw; i++) begin
        a = 0; b = 0;
        for (int k = 0; k < lw; k++) begin a[k] = n[i*lw+k]; b[k] = m[i*lw+k]; end
        if (sg && a[lw-1]) a = a - (64'sd1 <<< lw);
        if (sg && b[lw-1]) b = b - (64'sd1 <<< lw);
        hit = (kind == 0) ? (a == b) : (kind == 1) ? (a >= b) : (a > b);
        for (int k = 0; k < lw; k++) mk[i*lw+k] = hit;
      end
    end
  endtask

  function automatic logic [31:0] enc(input logic [3:0] f, input logic b4, input logic [1:0] sz);
    logic [31:0] w;
    w = $urandom;
    w[11:8] = f; w[4] = b4; w[21:20] = sz;
    return w;
  endfunction

  task automatic checkPend();
    if (!havePend) return;
    total++;
    if (outValid !== 1'b1 || outUndef !== pendUndef || outMask !== pendMask) begin
      bad++;
      $display("FAIL R%0d: valid=%0b undef=%0b mask=%h expected valid=1 undef=%0b mask=%h",
               pendReq, outValid, outUndef, outMask, pendUndef, pendMask);
    end
    if (pendSwap) begin
      // R11 complement against previous result
      total++;
      if (outMask !== ~lastMask) begin
        bad++;
        $display("FAIL R11: mask=%h expected %h", outMask, ~lastMask);
      end
    end
    lastMask = outMask;
  endtask

  task automatic step(input logic [31:0] ins, input logic u, input logic [127:0] n,
                      input logic [127:0] m, input int req, input bit swp);
    logic [127:0] mk;
    logic ud;
    @(negedge clk);
    checkPend();
    inValid = 1; inInstr = ins; inUGroup = u; opN = n; opM = m;
    refModel(ins, u, n, m, mk, ud);
    havePend = 1; pendMask = mk; pendUndef = ud; pendReq = req; pendSwap = swp;
  endtask

  task automatic idle();
    @(negedge clk);
    checkPend();
    havePend = 0;
    inValid = 0; inInstr = $urandom;
  endtask

  function automatic logic [31:0] fpPick();
    case ($urandom_range(0, 9))
      0: return 32'h0000_0000;
      1: return 32'h8000_0000;
      2: return 32'h7F80_0000;
      3: return 32'hFF80_0000;
      4: return 32'h7FC0_0001;
      5: return 32'h3F80_0000;
      6: return 32'hBF80_0000;
      7: return 32'h0000_0001;
      default: return $urandom;
    endcase
  endfunction

  function automatic logic [127:0] rnd128();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000 && !done) begin
        bad++; total++;
        $display("FAIL watchdog: cycles=%0d expected completion", cycles);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
      end
    end
  end

  initial begin
    logic [127:0] n, m;
    repeat (3) @(negedge clk);
    // R10 reset state
    total++;
    if (outValid !== 1'b0) begin bad++; $display("FAIL R10: valid=%0b expected 0", outValid); end
    rst = 0;
    idle();
    total++;
    if (outValid !== 1'b0) begin bad++; $display("FAIL R10: idle valid=%0b expected 0", outValid); end

    // R3 signed extremes, 8-bit lanes (R1 size 0)
    n = {16{8'h80}}; m = {16{8'h7F}};
    step(enc(4'h3, 1'b0, 2'd0), 1'b0, n, m, 3, 0);
    step(enc(4'h3, 1'b0, 2'd0), 1'b0, m, n, 3, 0);
    // R4 unsigned extremes 16-bit lanes (R1 size 1)
    n = {8{16'hFFFF}}; m = {8{16'h0000}};
    step(enc(4'h3, 1'b0, 2'd1), 1'b1, n, m, 4, 0);
    step(enc(4'h3, 1'b1, 2'd1), 1'b1, n, n, 4, 0);
    // R1 32-bit lanes, mixed
    n = 128'h8000_0000_7FFF_FFFF_0000_0005_FFFF_FFFF;
    m = 128'h7FFF_FFFF_8000_0000_0000_0005_0000_0000;
    step(enc(4'h3, 1'b1, 2'd2), 1'b0, n, m, 1, 0);
    // R5 integer equality
    step(enc(4'h8, 1'b1, 2'd2), 1'b1, n, m, 5, 0);
    step(enc(4'h8, 1'b1, 2'd0), 1'b1, n, n, 5, 0);
    // R6 float ordering with infinities and signed zeros
    n = 128'h7F80_0000_0000_0000_BF80_0000_3F80_0000;
    m = 128'h3F80_0000_8000_0000_FF80_0000_3F80_0000;
    step({enc(4'hE, 1'b0, 2'd0)}, 1'b1, n, m, 6, 0);
    step({enc(4'hE, 1'b0, 2'd2)}, 1'b1, n, m, 6, 0);
    // R8 NaN lanes and zeros
    n = 128'h7FC0_0000_0000_0000_8000_0000_7F80_0001;
    m = 128'h3F80_0000_8000_0000_0000_0000_7F80_0001;
    step(enc(4'hE, 1'b0, 2'd0), 1'b1, n, m, 8, 0);
    step(enc(4'hE, 1'b0, 2'd2), 1'b1, n, m, 8, 0);
    // R7 float equality
    step(enc(4'hE, 1'b0, 2'd0), 1'b0, n, m, 7, 0);
    // R9 illegal size and unknown encodings
    step(enc(4'h3, 1'b1, 2'd3), 1'b0, n, m, 9, 0);
    step(enc(4'h8, 1'b1, 2'd3), 1'b1, n, m, 9, 0);
    step(enc(4'h8, 1'b1, 2'd0), 1'b0, n, m, 9, 0);
    step(enc(4'hE, 1'b0, 2'd1), 1'b0, n, m, 9, 0);
    // R11 swap pairs
    n = rnd128(); m = rnd128();
    step(enc(4'h3, 1'b0, 2'd0), 1'b0, n, m, 11, 0);
    step(enc(4'h3, 1'b1, 2'd0), 1'b0, m, n, 11, 1);
    step(enc(4'h3, 1'b0, 2'd2), 1'b1, n, m, 11, 0);
    step(enc(4'h3, 1'b1, 2'd2), 1'b1, m, n, 11, 1);
    n = 128'h8000_0000_3F80_0000_FF80_0000_0000_0001;
    m = 128'h0000_0000_3F80_0000_BF80_0000_8000_0001;
    step(enc(4'hE, 1'b0, 2'd2), 1'b1, n, m, 11, 0);
    step(enc(4'hE, 1'b0, 2'd0), 1'b1, m, n, 11, 1);
    idle();
    // R10 no valid after idle
    @(negedge clk);
    total++;
    if (outValid !== 1'b0) begin bad++; $display("FAIL R10: valid=%0b expected 0", outValid); end

    // R2 random sweep across all encodings
    for (int t = 0; t < 3000; t++) begin
      int sel;
      logic [31:0] ins;
      logic u;
      sel = $urandom_range(0, 7);
      u = $urandom_range(0, 1);
      case (sel)
        0, 1: ins = enc(4'h3, 1'($urandom), 2'($urandom));
        2:    ins = enc(4'h8, 1'b1, 2'($urandom));
        3, 4: begin ins = enc(4'hE, 1'b0, 2'($urandom)); end
        default: ins = $urandom;
      endcase
      if (sel == 3 || sel == 4) begin
        for (int i = 0; i < 4; i++) begin n[i*32 +: 32] = fpPick(); m[i*32 +: 32] = fpPick(); end
        if ($urandom_range(0, 3) == 0) m = n;
      end else begin
        n = rnd128(); m = ($urandom_range(0, 3) == 0) ? n : rnd128();
        if ($urandom_range(0, 5) == 0) begin n = {16{8'h80}}; m = {16{8'h7F}}; end
      end
      step(ins, u, n, m, 2, 0);
      if ($urandom_range(0, 7) == 0) idle();
    end
    idle();
    idle();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule